// File: doc/BRIEF.md
# Fixed-Length HDLC-Style Frame Transmitter

The block turns one application message into one fixed-length HDLC-style frame on a one-way serial line that feeds an RS-485 line driver. Upstream logic pushes the data field byte by byte over a valid/ready interface: 23 payload bytes followed by a 4-byte end-to-end check word that upstream computes. The block frames these bytes with a two-byte message identifier and a control byte. It appends a 32-bit CRC frame check sequence that it computes as the bits leave. It inserts a zero after every run of five ones inside the frame and shifts everything out at a fixed line rate, one bit per `CLKS_PER_BIT` clocks. Every frame is 36 bytes long, both flags included.

The message identifier is made of a frame number (sent first) and a sender number. Both are sampled from their input pins when the first data byte of a message is accepted. Between frames the line carries back-to-back 0x7E flags. A message is staged completely before it goes out, so the sender cannot fall behind the line partway through a frame.

The sequencer has six states. `S_IDLE` sends idle flags and accepts data bytes. `S_ARMED` holds a full message until the current flag has gone out. `S_OPEN` sends the opening flag. `S_BODY` sends the identifier, control and data bytes. `S_FCS` sends the check sequence. `S_CLOSE` sends the closing flag. Transitions: fill-complete (`S_IDLE` to `S_ARMED`, on acceptance of the last data byte); boundary-start (`S_ARMED` to `S_OPEN`); open-done (`S_OPEN` to `S_BODY`); body-done (`S_BODY` to `S_FCS`); fcs-done (`S_FCS` to `S_CLOSE`); close-done (`S_CLOSE` to `S_IDLE`). All transitions except fill-complete happen on a bit tick at a byte boundary.

Top module: `hdlc_fixed_tx`

## Requirements
- R1: During and just after reset, `line_out` is 1, `bit_stb` is 0 and `in_ready` is 1.
- R2: `line_out` changes only on a bit tick. The first tick is at the `CLKS_PER_BIT`-th rising clock edge after reset is released, and later ticks follow every `CLKS_PER_BIT` clocks. `bit_stb` is high for exactly the one clock cycle after each tick, which is when the new bit first appears.
- R3: While no complete message is staged, the line carries back-to-back flags of 0x7E, each sent bit 0 first (0,1,1,1,1,1,1,0). Flags are never bit-stuffed.
- R4: `in_ready` is high only in `S_IDLE`. A byte is taken on each clock edge where `in_valid` and `in_ready` are both high. After the 27th byte is taken, `in_ready` stays low until the closing flag has been fully sent.
- R5: A staged message starts at the first byte boundary after staging completes. The frame is sent in this order: opening flag, frame number, sender number, control byte `CTRL_VALUE` (0x03), the 27 data bytes in the order they were accepted, the 4 FCS bytes, closing flag. That is 36 bytes in total, and each byte is sent least significant bit first.
- R6: The FCS is a CRC-32 with generator 0x04C11DB7, processed bit-reflected (LSB first), starting from 0xFFFFFFFF. It covers the identifier, control and data bytes, and the final value is complemented. The complemented value is sent least significant byte first, with bit 0 of each byte first.
- R7: From the first identifier bit through the last FCS bit, a 0 is inserted after every five consecutive 1 bits. This includes the case where the run ends on the last FCS bit. The run count restarts after an inserted 0.
- R8: The frame number and sender number used for a frame are the pin values at the clock edge where that message's first data byte is taken. Later changes on these pins have no effect on that frame.
- R9: When `in_ready` is low, `in_valid` and `in_data` have no effect. Bytes offered while a frame is staged or being sent do not appear in any frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_id | input | 8 | Frame number, sampled with the first data byte |
| sender_id | input | 8 | Sender number, sampled with the first data byte |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte (payload, then end-to-end check word) |
| in_ready | output | 1 | Block takes a byte this cycle if `in_valid` |
| line_out | output | 1 | Serial line bit to the line driver |
| bit_stb | output | 1 | One-cycle pulse marking a new bit on `line_out` |

## Verification
The assertions assume that `in_valid` and `in_data` only matter while `in_ready` is high. They also assume that upstream hands over exactly one message of 27 bytes at a time, and the identifier pins are free to move once the first byte has been taken. The stimulus changes inputs only on falling edges. It completes each message with gaps and burst patterns. It keeps `in_valid` asserted with a junk byte for the whole busy time and drops it in the same falling-edge window in which it sees `in_ready` return. It changes the identifier pins right after the first byte. Data patterns are chosen to force long runs of ones, runs across byte boundaries, and flag-like bytes inside the frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_OPEN,
        S_BODY,
        S_FCS,
        S_CLOSE
    } tx_state_e;

    localparam logic [7:0]  FLAG_BYTE     = 8'h7E;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320; // 0x04C11DB7 bit-reversed
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam int          HDR_BYTES     = 3;            // id hi, id lo, control
    localparam int          FCS_BYTES     = 4;
    localparam int          STUFF_RUN     = 5;

endpackage

// File: rtl/hdlc_bit_timer.sv
module hdlc_bit_timer #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/hdlc_data_buf.sv
module hdlc_data_buf #(
    parameter int NBYTES = 27,
    localparam int RW = $clog2(NBYTES),
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          clear,
    input  logic [RW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          empty,
    output logic          last
);
    logic [CW-1:0] cnt_q;
    logic [7:0]    slot [NBYTES];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (wr_en)      cnt_q <= cnt_q + 1'b1;
    end

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_en && (cnt_q == CW'(g))) slot[g] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = (int'(rd_idx) < NBYTES) ? slot[rd_idx] : 8'h00;
    assign empty   = (cnt_q == '0);
    assign last    = (cnt_q == CW'(NBYTES - 1));

    // R4
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(cnt_q) < NBYTES));

    // R4
    fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last) |=> !wr_en);

endmodule

// File: rtl/hdlc_crc32_ser.sv
module hdlc_crc32_ser
    import hdlc_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [31:0] crc
);
    logic [31:0] crc_q;
    logic        fb;

    assign fb  = crc_q[0] ^ din;
    assign crc = crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || init) crc_q <= CRC_SEED;
        else if (en)        crc_q <= (crc_q >> 1) ^ (fb ? CRC_POLY_REFL : 32'h0);
    end

    // R6
    crc_seeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc == CRC_SEED));

endmodule

// File: rtl/hdlc_fixed_tx.sv
module hdlc_fixed_tx
    import hdlc_tx_pkg::*;
#(
    parameter int         PAYLOAD_BYTES = 23,
    parameter int         CHECK_BYTES   = 4,
    parameter int         CLKS_PER_BIT  = 16,
    parameter logic [7:0] CTRL_VALUE    = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] frame_id,
    input  logic [7:0] sender_id,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       line_out,
    output logic       bit_stb
);
    localparam int DATA_BYTES = PAYLOAD_BYTES + CHECK_BYTES;
    localparam int BODY_BYTES = HDR_BYTES + DATA_BYTES;
    localparam int IW         = $clog2(BODY_BYTES);
    localparam int RW         = $clog2(DATA_BYTES);

    tx_state_e   state_q, state_d;
    logic [7:0]  sh_q, sh_d;
    logic [2:0]  left_q, left_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [2:0]  ones_q, ones_d;
    logic        line_q, line_d;
    logic        stb_q;
    logic [15:0] addr_q;

    logic        tick;
    logic        acc;
    logic        buf_empty, buf_last;
    logic [7:0]  buf_rd;
    logic [RW-1:0] rd_idx;
    logic        crc_init, crc_en, crc_bit;
    logic [31:0] crc_q;

    logic          stuffing;
    logic          stuff_now;
    logic [IW-1:0] sel_idx;
    logic [7:0]    body_sel;
    logic [1:0]    fsel;
    logic [7:0]    fcs_byte;
    logic [7:0]    nb;

    // ---------------- sub-blocks ----------------
    hdlc_bit_timer #(.DIV(CLKS_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    hdlc_data_buf #(.NBYTES(DATA_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc),
        .wr_data (in_data),
        .clear   (crc_init),
        .rd_idx  (rd_idx),
        .rd_data (buf_rd),
        .empty   (buf_empty),
        .last    (buf_last)
    );

    hdlc_crc32_ser u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .din   (crc_bit),
        .crc   (crc_q)
    );

    // ---------------- byte selection ----------------
    assign in_ready = (state_q == S_IDLE);
    assign acc      = in_valid && in_ready;
    assign stuffing = (state_q == S_BODY) || (state_q == S_FCS);
    assign stuff_now = stuffing && (ones_q == 3'(STUFF_RUN));

    assign sel_idx = (state_q == S_OPEN) ? '0 : idx_q + 1'b1;
    assign rd_idx  = RW'(sel_idx - IW'(HDR_BYTES));

    always_comb begin
        if (sel_idx == IW'(0))      body_sel = addr_q[15:8];
        else if (sel_idx == IW'(1)) body_sel = addr_q[7:0];
        else if (sel_idx == IW'(2)) body_sel = CTRL_VALUE;
        else                        body_sel = buf_rd;
    end

    assign fsel     = (state_q == S_FCS) ? (idx_q[1:0] + 2'd1) : 2'd0;
    assign fcs_byte = ~crc_q[{fsel, 3'b000} +: 8];

    // ---------------- next-state process ----------------
    always_comb begin
        state_d  = state_q;
        sh_d     = sh_q;
        left_d   = left_q;
        idx_d    = idx_q;
        ones_d   = ones_q;
        line_d   = line_q;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        crc_bit  = 1'b0;
        nb       = FLAG_BYTE;

        if (tick) begin
            if (stuff_now) begin
                line_d = 1'b0;
                ones_d = '0;
            end else begin
                if (left_q == 3'd0) begin
                    unique case (state_q)
                        S_IDLE: begin
                            state_d = S_IDLE;
                            nb      = FLAG_BYTE;
                        end
                        S_ARMED: begin
                            state_d  = S_OPEN;
                            nb       = FLAG_BYTE;
                            crc_init = 1'b1;
                        end
                        S_OPEN: begin
                            state_d = S_BODY;
                            idx_d   = '0;
                            nb      = body_sel;
                        end
                        S_BODY: begin
                            if (idx_q == IW'(BODY_BYTES - 1)) begin
                                state_d = S_FCS;
                                idx_d   = '0;
                                nb      = fcs_byte;
                            end else begin
                                idx_d = sel_idx;
                                nb    = body_sel;
                            end
                        end
                        S_FCS: begin
                            if (idx_q == IW'(FCS_BYTES - 1)) begin
                                state_d = S_CLOSE;
                                nb      = FLAG_BYTE;
                            end else begin
                                idx_d = idx_q + 1'b1;
                                nb    = fcs_byte;
                            end
                        end
                        S_CLOSE: begin
                            state_d = S_IDLE;
                            nb      = FLAG_BYTE;
                        end
                        default: begin
                            state_d = S_IDLE;
                            nb      = FLAG_BYTE;
                        end
                    endcase
                    line_d = nb[0];
                    sh_d   = {1'b0, nb[7:1]};
                    left_d = 3'd7;
                end else begin
                    line_d = sh_q[0];
                    sh_d   = {1'b0, sh_q[7:1]};
                    left_d = left_q - 1'b1;
                end

                if ((state_d == S_BODY) || (state_d == S_FCS))
                    ones_d = line_d ? (ones_q + 1'b1) : 3'd0;
                else
                    ones_d = '0;

                crc_en  = (state_d == S_BODY);
                crc_bit = line_d;
            end
        end

        if ((state_q == S_IDLE) && acc && buf_last)
            state_d = S_ARMED;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sh_q    <= '0;
            left_q  <= '0;
            idx_q   <= '0;
            ones_q  <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            left_q  <= left_d;
            idx_q   <= idx_d;
            ones_q  <= ones_d;
        end
    end

    // ---------------- output / capture register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
            stb_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            line_q <= line_d;
            stb_q  <= tick;
            if (acc && buf_empty) addr_q <= {frame_id, sender_id};
        end
    end

    assign line_out = line_q;
    assign bit_stb  = stb_q;

    // ---------------- assertions ----------------
    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |-> $stable(line_out));

    // R7
    run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= 3'(STUFF_RUN));

    // R7
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stuff_now) |=> !line_out);

    // R4
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(state_q == S_CLOSE));

    // R5
    fcs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_FCS) |-> $past(state_q == S_BODY));

    // R6
    crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FCS) |-> !crc_en);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(addr_q));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (state_q != S_IDLE) || $past(state_q == S_CLOSE));

endmodule

// File: tb/sim_hdlc_fixed_tx.sv
module sim_hdlc_fixed_tx;

    localparam int DIV    = 16;
    localparam int NDATA  = 27;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] frame_id, sender_id, in_data;
    logic       in_valid;
    logic       in_ready, line_out, bit_stb;

    always #2 clk = ~clk;

    hdlc_fixed_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_id  (frame_id),
        .sender_id (sender_id),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .line_out  (line_out),
        .bit_stb   (bit_stb)
    );

    int    vectors = 0;
    int    fails   = 0;
    string tag     = "R3 idle flags";

    // ---------------- behavioural reference ----------------
    bit         q[$];
    int         phase;
    int         mode;      // 0 filling, 1 staged, 2 sending
    int         fillc;
    logic [7:0] dbuf [NDATA];
    logic [15:0] mid;
    bit         exp_line, exp_stb;

    task automatic push_flag();
        for (int i = 0; i < 8; i++) q.push_back(((8'h7E >> i) & 8'h01) != 0);
    endtask

    task automatic push_frame();
        logic [7:0]  body [30];
        logic [31:0] c;
        logic [31:0] fcs;
        bit          raw [$];
        int          run;
        body[0] = mid[15:8];
        body[1] = mid[7:0];
        body[2] = 8'h03;
        for (int k = 0; k < NDATA; k++) body[3 + k] = dbuf[k];
        c = 32'hFFFFFFFF;
        for (int k = 0; k < 30; k++) begin
            for (int i = 0; i < 8; i++) begin
                raw.push_back(body[k][i]);
                if (c[0] ^ body[k][i]) c = (c >> 1) ^ 32'hEDB88320;
                else                   c = c >> 1;
            end
        end
        fcs = ~c;
        for (int i = 0; i < 32; i++) raw.push_back(fcs[i]);
        push_flag();
        run = 0;
        foreach (raw[i]) begin
            q.push_back(raw[i]);
            if (raw[i]) run++; else run = 0;
            if (run == 5) begin
                q.push_back(1'b0);
                run = 0;
            end
        end
        push_flag();
    endtask

    always @(posedge clk) begin : model
        int mpre;
        if (!rst_n) begin
            q.delete();
            phase    = 0;
            mode     = 0;
            fillc    = 0;
            exp_line = 1'b1;
            exp_stb  = 1'b0;
        end else begin
            mpre = mode;
            if (phase == DIV - 1) begin
                phase = 0;
                if (q.size() == 0) begin
                    if (mode == 1) begin
                        push_frame();
                        mode = 2;
                    end else begin
                        if (mode == 2) mode = 0;
                        push_flag();
                    end
                end
                exp_line = q.pop_front();
                exp_stb  = 1'b1;
            end else begin
                phase++;
                exp_stb = 1'b0;
            end
            if (mpre == 0 && in_valid) begin
                if (fillc == 0) mid = {frame_id, sender_id};
                dbuf[fillc] = in_data;
                fillc++;
                if (fillc == NDATA) begin
                    mode  = 1;
                    fillc = 0;
                end
            end
        end
    end

    task automatic chk(input string t, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", t, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, line_out, exp_line);
            chk("R2 bit strobe", bit_stb, exp_stb);
            chk("R4 in_ready", in_ready, (mode == 0));
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] pat(input int kind, input int k);
        case (kind)
            0:       return 8'(k + 1);
            1:       return 8'hFF;
            2:       return 8'h00;
            3:       return 8'h7E;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic send_msg(input logic [7:0] fid, input logic [7:0] sid,
                            input int kind, input bit gaps, input bit hammer);
        int k = 0;
        while (k < NDATA) begin
            @(negedge clk);
            frame_id  = (k == 0) ? fid : ~fid;   // R8: pins move after first byte
            sender_id = (k == 0) ? sid : 8'h5A;
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = pat(kind, k);
                if (in_ready) k++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (hammer) begin
            // R9: offer junk for the whole busy time
            while (!in_ready) begin
                in_valid = 1'b1;
                in_data  = 8'hA5;
                @(negedge clk);
            end
            in_valid = 1'b0;
        end else begin
            while (!in_ready) @(negedge clk);
        end
        repeat (3 * 8 * DIV) @(negedge clk);
    endtask

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        frame_id  = 8'h00;
        sender_id = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 line during reset", line_out, 1'b1);
        chk("R1 strobe during reset", bit_stb, 1'b0);
        chk("R1 ready during reset", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line after reset", line_out, 1'b1);
        tag = "R3 idle flags";
        repeat (5 * 8 * DIV) @(negedge clk);

        tag = "R5 frame layout counting bytes";
        send_msg(8'h12, 8'h34, 0, 1'b0, 1'b0);
        tag = "R7 zero insertion on ones";
        send_msg(8'hFF, 8'hFF, 1, 1'b0, 1'b0);
        tag = "R6 fcs over zero data";
        send_msg(8'h00, 8'h00, 2, 1'b1, 1'b0);
        tag = "R8 id sampled at first byte";
        send_msg(8'hC3, 8'h81, 3, 1'b1, 1'b0);
        tag = "R9 busy bytes ignored";
        send_msg(8'h7E, 8'h01, 4, 1'b0, 1'b1);
        tag = "R9 frame after busy offers";
        send_msg(8'h2D, 8'hE7, 4, 1'b1, 1'b0);
        tag = "R3 idle after frames";
        repeat (3 * 8 * DIV) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule